// File: doc/BRIEF.md
# Bus Protection Violation Monitor

This block watches every bus access the system bus controller presents to it and spots eight kinds of protection or error condition. Two chip-select regions claiming the same address, a write into read-only space, a read from write-only space and a user-mode access to supervisor-only space are the access-protection cases. The error cases are an access to a peripheral whose clock is stopped, a peripheral access that ends in a transfer error, a watchdog timeout and an external transfer error. Each condition sets its own sticky status flag. When the enable paired with that flag is set, the block also asks the bus controller to end the current cycle with an access-error response.

Upstream logic has already classified the access. The block receives the access direction, the privilege mode, the attribute flags of the matched region, the raw chip-select match lines and the peripheral and error events. Software sees one 16-bit register on a simple register bus. The register holds the eight status flags in its upper byte and the eight enables in its lower byte. Status flags are cleared by writing ones to them. The enables are ordinary read/write bits.

Top module: `prot_monitor`

## Requirements
- R1: The register answers only at offset 0x006. Bits 15..8 hold the status flags and bits 7..0 hold the enables, and each enable sits 8 bits below its flag. From the most significant bit down, the flags are: decode conflict (15), write-protect (14), stopped-peripheral (13), peripheral error (12), watchdog timeout (11), read-protect (10), external error (9), privilege violation (8). A read at any other offset returns 0, and a write at any other offset changes nothing.
- R2: After reset, all status flags are 0 and the enable byte is 0x0B. This means the watchdog, external-error and privilege enables are on.
- R3: On a valid access, the following conditions each set their flag: two or more chip-select matches (decode conflict), a write to a read-only region (write-protect), a read from a write-only region (read-protect), a user-mode access to a supervisor-only region (privilege), the stopped-peripheral input (stopped-peripheral) and the peripheral transfer-error input (peripheral error).
- R4: The watchdog-timeout and external-error inputs set their flags in any cycle they are high, whether or not an access is valid.
- R5: Status flags are sticky and are cleared only by writing a 1 to them. Writing 0 to a flag leaves it unchanged. If a set and a clear hit the same flag in the same cycle, the set wins.
- R6: In the cycle an access is valid, `accErr` is high exactly when at least one condition detected in that cycle has its enable at 1. The flag is recorded whatever the enable is.
- R7: `accErr` is never high in a cycle without a valid access, and never high for an access that raises no enabled condition.
- R8: Enables are plain read/write bits that read back as written. An enable written in the same cycle as an access first takes effect on the next cycle.
- R9: A flag set by a condition is visible on a register read in the cycle after detection. A read returns both bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| accValid | input | 1 | A bus access is evaluated this cycle |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accUser | input | 1 | 1 = user mode, 0 = supervisor mode |
| rgnReadOnly | input | 1 | The matched region is read-only |
| rgnWriteOnly | input | 1 | The matched region is write-only |
| rgnSuperOnly | input | 1 | The matched region is supervisor-only |
| csMatch | input | CS_COUNT | Chip-select match lines for the access address |
| perStopped | input | 1 | The accessed peripheral has its clock stopped |
| perXferErr | input | 1 | The peripheral access ended in a transfer error |
| wdtTimeout | input | 1 | Watchdog timeout event |
| extXferErr | input | 1 | External transfer-error input |
| regSel | input | 1 | Register bus select |
| regWrite | input | 1 | Register bus write strobe |
| regAddr | input | ADDR_W | Register bus byte offset |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| accErr | output | 1 | Terminate the current access with an access error |

## Verification
The bench targets the following corner cases, and for each one names the fault it would expose:

- **Set and clear in the same cycle.** The bench raises a condition on a flag in the same cycle software writes a 1 to clear that flag. A design that lets the clear win would lose the event.
- **Exactly one versus two chip-select matches.** A miscounting conflict detector would either flag every access or miss real overlaps.
- **Watchdog and external events with no access in progress.** A design that gates these events with the access-valid input would drop the flag. A design that does not gate the abort with access-valid would pulse an error onto an idle bus.
- **Disabled conditions.** With a condition's enable cleared, the flag must still be set but no abort may be produced.
- **Enable write during an access.** An enable written in the same cycle as an access must not affect that access.
- **Writes of 0 and writes at a wrong offset.** These must leave the register untouched. A missing offset compare or a write-one-to-set mix-up shows up as changed readback.

// File: rtl/prot_mon_pkg.sv
package prot_mon_pkg;

  localparam int SRC_COUNT = 8;
  localparam int REG_W     = 2 * SRC_COUNT;

  // Source positions inside each byte; enable = bit i, status = bit i + SRC_COUNT.
  // The order sets the register layout the software reads.
  localparam int IDX_PRIV    = 0;
  localparam int IDX_EXTERR  = 1;
  localparam int IDX_RDPROT  = 2;
  localparam int IDX_WDOG    = 3;
  localparam int IDX_PERERR  = 4;
  localparam int IDX_STOPPED = 5;
  localparam int IDX_WRPROT  = 6;
  localparam int IDX_DECODE  = 7;

  typedef struct packed {
    logic [SRC_COUNT-1:0] hit;      // conditions detected this cycle
    logic [SRC_COUNT-1:0] clrMask;  // write-one-to-clear mask for status
    logic                 enLoad;   // load enable byte
    logic [SRC_COUNT-1:0] enData;   // new enable byte
    logic                 rdSel;    // drive register onto read data
  } strobe_t;

endpackage

// File: rtl/prot_mon_ctrl.sv
module prot_mon_ctrl
  import prot_mon_pkg::*;
#(
  parameter int CS_COUNT   = 4,
  parameter int ADDR_W     = 8,
  parameter int REG_OFFSET = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accValid,
  input  logic                 accWrite,
  input  logic                 accUser,
  input  logic                 rgnReadOnly,
  input  logic                 rgnWriteOnly,
  input  logic                 rgnSuperOnly,
  input  logic [CS_COUNT-1:0]  csMatch,
  input  logic                 perStopped,
  input  logic                 perXferErr,
  input  logic                 wdtTimeout,
  input  logic                 extXferErr,
  input  logic                 regSel,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWdata,
  input  logic [SRC_COUNT-1:0] enables,
  output strobe_t              strb,
  output logic                 accErr
);

  localparam logic [ADDR_W-1:0] OFFSET_ADDR = ADDR_W'(REG_OFFSET);

  logic csSeen  [CS_COUNT+1];
  logic csMulti [CS_COUNT+1];
  logic decodeConflict;
  logic regHit;
  logic [SRC_COUNT-1:0] hitVec;

  // Two-or-more detector as a chain: multi rises once a match follows an earlier one.
  assign csSeen[0]  = 1'b0;
  assign csMulti[0] = 1'b0;
  generate
    for (genvar g = 0; g < CS_COUNT; g++) begin : g_cs
      assign csMulti[g+1] = csMulti[g] | (csSeen[g] & csMatch[g]);
      assign csSeen[g+1]  = csSeen[g] | csMatch[g];
    end
  endgenerate
  assign decodeConflict = csMulti[CS_COUNT];

  always_comb begin
    hitVec              = '0;
    hitVec[IDX_DECODE]  = accValid & decodeConflict;
    hitVec[IDX_WRPROT]  = accValid & accWrite & rgnReadOnly;
    hitVec[IDX_STOPPED] = accValid & perStopped;
    hitVec[IDX_PERERR]  = accValid & perXferErr;
    hitVec[IDX_WDOG]    = wdtTimeout;
    hitVec[IDX_RDPROT]  = accValid & ~accWrite & rgnWriteOnly;
    hitVec[IDX_EXTERR]  = extXferErr;
    hitVec[IDX_PRIV]    = accValid & accUser & rgnSuperOnly;
  end

  assign regHit = regSel && (regAddr == OFFSET_ADDR);

  always_comb begin
    strb.hit     = hitVec;
    strb.enLoad  = regHit & regWrite;
    strb.enData  = regWdata[SRC_COUNT-1:0];
    strb.clrMask = (regHit & regWrite) ? regWdata[REG_W-1:SRC_COUNT] : '0;
    strb.rdSel   = regHit & ~regWrite;
  end

  assign accErr = accValid & |(hitVec & enables);

  // R7: no abort outside a valid access
  a_r7_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    accErr |-> accValid);

  // R7: no abort when nothing was detected this cycle
  a_r7_err_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.hit == '0) |-> !accErr);

  // R1: clear and load strobes never fire together with a read select
  a_r1_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdSel |-> (!strb.enLoad && strb.clrMask == '0));

endmodule

// File: rtl/prot_mon_dp.sv
module prot_mon_dp
  import prot_mon_pkg::*;
#(
  parameter logic [SRC_COUNT-1:0] EN_RESET = 8'h0B
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              strb,
  output logic [SRC_COUNT-1:0] statusQ,
  output logic [SRC_COUNT-1:0] enableQ,
  output logic [REG_W-1:0]     rdData
);

  logic [SRC_COUNT-1:0] statusNext;
  logic [SRC_COUNT-1:0] enableNext;

  // Hardware set has priority over a software clear in the same cycle.
  assign statusNext = (statusQ & ~strb.clrMask) | strb.hit;
  assign enableNext = strb.enLoad ? strb.enData : enableQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= '0;
      enableQ <= EN_RESET;
    end else begin
      statusQ <= statusNext;
      enableQ <= enableNext;
    end
  end

  assign rdData = strb.rdSel ? {statusQ, enableQ} : '0;

  generate
    for (genvar g = 0; g < SRC_COUNT; g++) begin : g_chk
      // R5: a flag only drops after a write-one to it
      a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (statusQ[g] && !strb.clrMask[g]) |=> statusQ[g]);
      // R9: a detected condition is visible the next cycle
      a_r9_hit_visible: assert property (@(posedge clk) disable iff (!rst_n)
        strb.hit[g] |=> statusQ[g]);
      // R5: a flag never rises without a detection
      a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!statusQ[g] && !strb.hit[g]) |=> !statusQ[g]);
    end
  endgenerate

  // R8: enables hold unless loaded
  a_r8_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.enLoad |=> $stable(enableQ));

endmodule

// File: rtl/prot_monitor.sv
module prot_monitor
  import prot_mon_pkg::*;
#(
  parameter int                   CS_COUNT   = 4,
  parameter int                   ADDR_W     = 8,
  parameter int                   REG_OFFSET = 6,
  parameter logic [SRC_COUNT-1:0] EN_RESET   = 8'h0B
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accValid,
  input  logic                accWrite,
  input  logic                accUser,
  input  logic                rgnReadOnly,
  input  logic                rgnWriteOnly,
  input  logic                rgnSuperOnly,
  input  logic [CS_COUNT-1:0] csMatch,
  input  logic                perStopped,
  input  logic                perXferErr,
  input  logic                wdtTimeout,
  input  logic                extXferErr,
  input  logic                regSel,
  input  logic                regWrite,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  output logic                accErr
);

  strobe_t              strb;
  logic [SRC_COUNT-1:0] statusQ;
  logic [SRC_COUNT-1:0] enableQ;

  prot_mon_ctrl #(
    .CS_COUNT  (CS_COUNT),
    .ADDR_W    (ADDR_W),
    .REG_OFFSET(REG_OFFSET)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .accValid    (accValid),
    .accWrite    (accWrite),
    .accUser     (accUser),
    .rgnReadOnly (rgnReadOnly),
    .rgnWriteOnly(rgnWriteOnly),
    .rgnSuperOnly(rgnSuperOnly),
    .csMatch     (csMatch),
    .perStopped  (perStopped),
    .perXferErr  (perXferErr),
    .wdtTimeout  (wdtTimeout),
    .extXferErr  (extXferErr),
    .regSel      (regSel),
    .regWrite    (regWrite),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .enables     (enableQ),
    .strb        (strb),
    .accErr      (accErr)
  );

  prot_mon_dp #(
    .EN_RESET(EN_RESET)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .statusQ(statusQ),
    .enableQ(enableQ),
    .rdData (regRdata)
  );

  // R6: an abort always leaves an enabled flag set behind it
  a_r6_abort_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    accErr |=> |(statusQ & $past(enableQ)));

  // R3: overlapping chip selects on an access set the decode-conflict flag
  a_r3_conflict_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && $countones(csMatch) >= 2) |=> statusQ[IDX_DECODE]);

  // R4: watchdog event is recorded even with no access
  a_r4_wdog_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wdtTimeout |=> statusQ[IDX_WDOG]);

endmodule

// File: tb/prot_monitor_test.sv
module prot_monitor_test;

  localparam int CLK_PERIOD = 10;
  localparam int CS_N = 4;
  localparam logic [7:0] OFF = 8'h06;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic        accValid, accWrite, accUser;
  logic        rgnReadOnly, rgnWriteOnly, rgnSuperOnly;
  logic [CS_N-1:0] csMatch;
  logic        perStopped, perXferErr, wdtTimeout, extXferErr;
  logic        regSel, regWrite;
  logic [7:0]  regAddr;
  logic [15:0] regWdata;
  logic [15:0] regRdata;
  logic        accErr;

  int checks = 0;
  int errors = 0;
  logic [7:0] mStat;
  logic [7:0] mEn;

  prot_monitor uut (
    .clk(clk), .rst_n(rst_n),
    .accValid(accValid), .accWrite(accWrite), .accUser(accUser),
    .rgnReadOnly(rgnReadOnly), .rgnWriteOnly(rgnWriteOnly), .rgnSuperOnly(rgnSuperOnly),
    .csMatch(csMatch), .perStopped(perStopped), .perXferErr(perXferErr),
    .wdtTimeout(wdtTimeout), .extXferErr(extXferErr),
    .regSel(regSel), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .accErr(accErr)
  );

  // Expected detections from the requirement text (R3, R4); bit 7 = decode conflict ... bit 0 = privilege.
  function automatic logic [7:0] calcHits();
    logic [7:0] h = '0;
    int n = 0;
    for (int i = 0; i < CS_N; i++) n += int'(csMatch[i]);
    h[7] = accValid && (n >= 2);
    h[6] = accValid && accWrite && rgnReadOnly;
    h[5] = accValid && perStopped;
    h[4] = accValid && perXferErr;
    h[3] = wdtTimeout;
    h[2] = accValid && !accWrite && rgnWriteOnly;
    h[1] = extXferErr;
    h[0] = accValid && accUser && rgnSuperOnly;
    return h;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    accValid = 0; accWrite = 0; accUser = 0;
    rgnReadOnly = 0; rgnWriteOnly = 0; rgnSuperOnly = 0;
    csMatch = '0; perStopped = 0; perXferErr = 0;
    wdtTimeout = 0; extXferErr = 0;
    regSel = 0; regWrite = 0; regAddr = '0; regWdata = '0;
  endtask

  // Called just after a falling edge with inputs set; checks, clocks, updates the model.
  task automatic step(input string req);
    logic [7:0] h;
    logic [7:0] clr;
    #1;
    h = calcHits();
    check(req, {15'd0, accErr}, {15'd0, accValid && |(h & mEn)});
    if (regSel && !regWrite)
      check(req, regRdata, (regAddr == OFF) ? {mStat, mEn} : 16'h0000);
    clr = (regSel && regWrite && regAddr == OFF) ? regWdata[15:8] : 8'h00;
    @(posedge clk);
    mStat = (mStat & ~clr) | h;
    if (regSel && regWrite && regAddr == OFF) mEn = regWdata[7:0];
    @(negedge clk);
  endtask

  task automatic readReg(input string req, input logic [7:0] addr);
    idle(); regSel = 1; regAddr = addr; step(req); idle();
  endtask

  task automatic writeReg(input string req, input logic [7:0] addr, input logic [15:0] d);
    idle(); regSel = 1; regWrite = 1; regAddr = addr; regWdata = d; step(req); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    mStat = 8'h00; mEn = 8'h0B;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset value
    readReg("R2 reset", OFF);
    // R1 wrong offset reads 0, writes ignored
    readReg("R1 other offset", 8'h04);
    writeReg("R1 write other offset", 8'h04, 16'hFFFF);
    readReg("R1 unchanged", OFF);

    // R8 enables read back as written
    writeReg("R8 en write", OFF, 16'h00A5);
    readReg("R8 en readback", OFF);
    writeReg("R8 en all", OFF, 16'h00FF);

    // R3 each access condition alone
    idle(); accValid = 1; accWrite = 1; rgnReadOnly = 1; step("R3 write-protect");
    idle(); accValid = 1; accWrite = 1; rgnWriteOnly = 1; step("R3 write to wo region ok");
    idle(); accValid = 1; rgnWriteOnly = 1; step("R3 read-protect");
    idle(); accValid = 1; accUser = 1; rgnSuperOnly = 1; step("R3 privilege");
    idle(); accValid = 1; rgnSuperOnly = 1; step("R3 supervisor ok");
    idle(); accValid = 1; perStopped = 1; step("R3 stopped");
    idle(); accValid = 1; perXferErr = 1; step("R3 per error");
    readReg("R9 flags visible", OFF);
    writeReg("R5 clear all", OFF, 16'hFFFF);
    readReg("R5 cleared", OFF);

    // R3 conflict: one match none, two matches flagged
    idle(); accValid = 1; csMatch = 4'b0100; step("R3 single cs");
    readReg("R3 single cs no flag", OFF);
    idle(); accValid = 1; csMatch = 4'b1001; step("R3 double cs");
    readReg("R3 conflict flag", OFF);

    // R5 writing zero changes nothing; set wins over clear
    writeReg("R5 write zero", OFF, 16'h00FF);
    readReg("R5 zero no clear", OFF);
    idle(); accValid = 1; accWrite = 1; rgnReadOnly = 1;
    regSel = 1; regWrite = 1; regAddr = OFF; regWdata = 16'hC0FF;
    step("R5 set beats clear");
    readReg("R5 set beats clear read", OFF);

    // R4 watchdog / external with no access: flag set, no abort (R7)
    writeReg("R5 clear", OFF, 16'hFF0B);
    idle(); wdtTimeout = 1; step("R4 R7 wdog idle");
    idle(); extXferErr = 1; step("R4 R7 ext idle");
    readReg("R4 flags", OFF);

    // R6 disabled condition records but does not abort
    writeReg("R6 en off", OFF, 16'hFF00);
    idle(); accValid = 1; accUser = 1; rgnSuperOnly = 1; wdtTimeout = 1; step("R6 disabled");
    readReg("R6 recorded", OFF);

    // R8 enable written during an access applies next cycle
    idle(); accValid = 1; perStopped = 1;
    regSel = 1; regWrite = 1; regAddr = OFF; regWdata = 16'h0020;
    step("R8 same-cycle enable");
    idle(); accValid = 1; perStopped = 1; step("R8 enable now active");

    // Random mix (R3 R4 R5 R6 R7 R8 R9)
    begin
      int unsigned seed = 32'd20240611;
      void'($urandom(seed));
      for (int k = 0; k < 3000; k++) begin
        int unsigned r;
        idle();
        r = $urandom;
        accValid     = r[0] | r[1];
        accWrite     = r[2];
        accUser      = r[3];
        rgnReadOnly  = (r[7:4] == 0);
        rgnWriteOnly = (r[11:8] == 0);
        rgnSuperOnly = (r[14:12] == 0);
        for (int c = 0; c < CS_N; c++) csMatch[c] = ($urandom % 5 == 0);
        perStopped   = ($urandom % 16 == 0);
        perXferErr   = ($urandom % 16 == 0);
        wdtTimeout   = ($urandom % 24 == 0);
        extXferErr   = ($urandom % 24 == 0);
        r = $urandom % 10;
        regSel = 1;
        regAddr = ($urandom % 8 == 0) ? 8'h02 : OFF;
        if (r < 2) begin
          regWrite = 1;
          regWdata = 16'($urandom);
        end
        step("R6 R5 random");
      end
    end

    idle();
    readReg("R9 final", OFF);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule